// File: doc/BRIEF.md
# General-Purpose Port with Serial-Interface Pin Takeover

This block is an 8-bit general-purpose I/O port. It has a data latch and a direction register, which the CPU writes and reads. Each pin has an output-enable and an output value. Pin levels are sampled through a two-flop synchronizer before any internal logic uses them.

The lowest three pins can be handed to a serial peripheral interface. While the serial enable is high, pin 0 is the serial data input and pin 1 is the serial data output. Pin 2 carries the serial clock. It is an output in master mode and an input in slave mode. In this mode the direction register loses control of those three pins. It only selects whether a CPU read of each of those bits returns the latch or the synchronized pin level. The five upper pins remain ordinary I/O at all times.

When the serial enable is cleared, pins 0 to 2 return to ordinary I/O. Latch writes made while the serial interface owned the pins are kept, so the pins then drive the last written values.

Top module: `gpio_spi_port`

## Requirements
- R1: After reset the direction register reads 0x00 and the data latch holds 0x00. With all pin inputs low, the data read returns 0x00.
- R2: A write strobe loads the write data into the latch or into the direction register on the next rising edge. A latch write is stored whatever the serial enable is, and the direction register is readable on `cpu_dir_rd`.
- R3: Bits 3 to 7 always behave as ordinary I/O, as do bits 0 to 2 while `spi_en` is 0. `pin_oe[i]` equals direction bit i, and `pin_out[i]` equals latch bit i.
- R4: While `spi_en` is 1, `pin_oe[0]` is 0 and `pin_out[0]` is 0. `pin_oe[1]` is 1 and `pin_out[1]` equals `spi_sdo`, in both master and slave mode.
- R5: While `spi_en` is 1, pin 2 depends on `spi_master`. When `spi_master` is 1, `pin_oe[2]`=1 and `pin_out[2]`=`spi_sck_out`. When `spi_master` is 0, `pin_oe[2]`=0, `pin_out[2]`=0 and `spi_sck_in` equals the synchronized pin 2 level. In every other case `spi_sck_in` is 0.
- R6: While `spi_en` is 1, direction bits 0 to 2 have no effect on `pin_oe[2:0]`.
- R7: In every mode, read bit i returns latch bit i when direction bit i is 1, and the synchronized level of pin i when it is 0.
- R8: A change on `pin_in` shows up in the read data and in the serial inputs after the second rising edge, and not after the first.
- R9: `spi_sdi` equals the synchronized pin 0 level while `spi_en` is 1, and is 0 otherwise.
- R10: When `spi_en` falls, pins 0 to 2 drive the latch values at once, including values written while the serial interface owned them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_data | input | 8 | Write data for latch or direction register |
| cpu_data_we | input | 1 | Latch write strobe |
| cpu_dir_we | input | 1 | Direction register write strobe |
| cpu_data_rd | output | 8 | Data read (latch or pin level per bit) |
| cpu_dir_rd | output | 8 | Direction register read |
| pin_in | input | 8 | Raw pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| spi_en | input | 1 | Serial interface owns pins 0 to 2 |
| spi_master | input | 1 | Serial interface is clock master |
| spi_sdo | input | 1 | Serial data out from the shifter |
| spi_sck_out | input | 1 | Serial clock out from the shifter |
| spi_sdi | output | 1 | Synchronized serial data in |
| spi_sck_in | output | 1 | Synchronized serial clock in (slave mode) |

## Verification
Register writes are due one edge after the strobe. Pin enables and values follow the mode inputs and the registers in the same cycle. Pin levels reach the read data and the serial inputs two edges after they change. The bench drives inputs on the falling edge and advances a behavioural model on each rising edge, with a two-entry queue standing in for the synchronizer. It then compares every output on the next falling edge, so each result is checked in the cycle it is due. A directed step checks the second-edge latency of the synchronizer explicitly.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_W   = 8;
  localparam int SDI_BIT  = 0;
  localparam int SDO_BIT  = 1;
  localparam int SCK_BIT  = 2;
  localparam int SYNC_STG = 2;
endpackage

// File: rtl/port_rst_sync.sv
module port_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/port_pin_sync.sv
module port_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = raw_in;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/port_regs.sv
module port_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wr_data,
  input  logic         latch_we,
  input  logic         dir_we,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q
);
  logic [W-1:0] latch_d;
  logic [W-1:0] dir_d;

  always_comb begin
    latch_d = latch_q;
    dir_d   = dir_q;
    if (latch_we) latch_d = wr_data;
    if (dir_we)   dir_d   = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
    end
  end
endmodule

// File: rtl/port_pin_route.sv
module port_pin_route
  import gpio_port_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] pin_sync,
  input  logic         spi_en,
  input  logic         spi_master,
  input  logic         spi_sdo,
  input  logic         spi_sck_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] rd_data,
  output logic         spi_sdi,
  output logic         spi_sck_in
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      if (i == SDI_BIT) begin : g_sdi
        assign pin_oe[i]  = spi_en ? 1'b0 : dir_q[i];
        assign pin_out[i] = spi_en ? 1'b0 : latch_q[i];
      end else if (i == SDO_BIT) begin : g_sdo
        assign pin_oe[i]  = spi_en ? 1'b1 : dir_q[i];
        assign pin_out[i] = spi_en ? spi_sdo : latch_q[i];
      end else if (i == SCK_BIT) begin : g_sck
        assign pin_oe[i]  = spi_en ? spi_master : dir_q[i];
        assign pin_out[i] = spi_en ? (spi_master & spi_sck_out) : latch_q[i];
      end else begin : g_gpio
        assign pin_oe[i]  = dir_q[i];
        assign pin_out[i] = latch_q[i];
      end
      assign rd_data[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
    end
  endgenerate

  assign spi_sdi    = spi_en & pin_sync[SDI_BIT];
  assign spi_sck_in = spi_en & ~spi_master & pin_sync[SCK_BIT];
endmodule

// File: rtl/gpio_spi_port.sv
module gpio_spi_port
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] cpu_wr_data,
  input  logic              cpu_data_we,
  input  logic              cpu_dir_we,
  output logic [PORT_W-1:0] cpu_data_rd,
  output logic [PORT_W-1:0] cpu_dir_rd,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] pin_out,
  input  logic              spi_en,
  input  logic              spi_master,
  input  logic              spi_sdo,
  input  logic              spi_sck_out,
  output logic              spi_sdi,
  output logic              spi_sck_in
);
  logic              rst_int_n;
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] pin_sync;

  port_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_int_n)
  );

  port_pin_sync #(.W(PORT_W), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .raw_in(pin_in), .sync_out(pin_sync)
  );

  port_regs #(.W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_data(cpu_wr_data),
    .latch_we(cpu_data_we), .dir_we(cpu_dir_we),
    .latch_q(latch_q), .dir_q(dir_q)
  );

  port_pin_route #(.W(PORT_W)) u_route (
    .latch_q(latch_q), .dir_q(dir_q), .pin_sync(pin_sync),
    .spi_en(spi_en), .spi_master(spi_master), .spi_sdo(spi_sdo),
    .spi_sck_out(spi_sck_out), .pin_oe(pin_oe), .pin_out(pin_out),
    .rd_data(cpu_data_rd), .spi_sdi(spi_sdi), .spi_sck_in(spi_sck_in)
  );

  assign cpu_dir_rd = dir_q;
endmodule

// File: rtl/gpio_spi_port_chk.sv
module gpio_spi_port_chk (
  input logic       clk,
  input logic       rst_int_n,
  input logic [7:0] cpu_wr_data,
  input logic       cpu_data_we,
  input logic       cpu_dir_we,
  input logic [7:0] cpu_data_rd,
  input logic [7:0] cpu_dir_rd,
  input logic [7:0] pin_in,
  input logic [7:0] pin_oe,
  input logic [7:0] pin_out,
  input logic       spi_en,
  input logic       spi_master,
  input logic       spi_sdo
);
  logic [1:0] age_q;
  logic [1:0] age_d;

  always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) age_q <= '0;
    else            age_q <= age_d;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_int_n) |-> (cpu_dir_rd == 8'h00));

  assert_latch_write_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_data_we && !cpu_dir_we) |=> (((cpu_data_rd ^ $past(cpu_wr_data)) & cpu_dir_rd) == 8'h00));

  assert_upper_gpio_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    pin_oe[7:3] == cpu_dir_rd[7:3]);

  assert_fixed_roles_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    spi_en |-> (!pin_oe[0] && pin_oe[1] && (pin_out[1] == spi_sdo)));

  assert_sck_dir_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    spi_en |-> (pin_oe[2] == spi_master));

  assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age_q == 2'd3) |-> (((cpu_data_rd ^ $past(pin_in, 2)) & ~cpu_dir_rd) == 8'h00));
endmodule

bind gpio_spi_port gpio_spi_port_chk u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .cpu_wr_data(cpu_wr_data),
  .cpu_data_we(cpu_data_we), .cpu_dir_we(cpu_dir_we),
  .cpu_data_rd(cpu_data_rd), .cpu_dir_rd(cpu_dir_rd), .pin_in(pin_in),
  .pin_oe(pin_oe), .pin_out(pin_out), .spi_en(spi_en),
  .spi_master(spi_master), .spi_sdo(spi_sdo)
);

// File: tb/gpio_spi_port_test.sv
`timescale 1ns/1ps
module gpio_spi_port_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cpu_wr_data;
  logic       cpu_data_we, cpu_dir_we;
  logic [7:0] cpu_data_rd, cpu_dir_rd;
  logic [7:0] pin_in, pin_oe, pin_out;
  logic       spi_en, spi_master, spi_sdo, spi_sck_out;
  logic       spi_sdi, spi_sck_in;

  int vectors = 0;
  int errors  = 0;
  bit model_on = 0;
  bit done = 0;
  string phase = "R1";

  logic [7:0] m_latch, m_dir;
  logic [7:0] hist[$];

  always #10 clk = ~clk;

  gpio_spi_port uut (.*);

  function automatic logic [7:0] synced();
    return hist[0];
  endfunction

  always @(posedge clk) begin
    if (model_on) begin
      if (cpu_data_we) m_latch = cpu_wr_data;
      if (cpu_dir_we)  m_dir   = cpu_wr_data;
      hist.push_back(pin_in);
      void'(hist.pop_front());
    end
  end

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) %s: actual %h expected %h at %0t", req, phase, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e_oe, e_out, e_rd, s;
    logic e_sdi, e_sck;
    s = synced();
    for (int i = 0; i < 8; i++) begin
      e_oe[i]  = m_dir[i];
      e_out[i] = m_latch[i];
      e_rd[i]  = m_dir[i] ? m_latch[i] : s[i];
    end
    if (spi_en) begin
      e_oe[0] = 1'b0;  e_out[0] = 1'b0;
      e_oe[1] = 1'b1;  e_out[1] = spi_sdo;
      e_oe[2] = spi_master; e_out[2] = spi_master ? spi_sck_out : 1'b0;
    end
    e_sdi = spi_en & s[0];
    e_sck = spi_en & ~spi_master & s[2];
    check("R3", "pin_oe[7:3]", {3'b0, pin_oe[7:3]}, {3'b0, e_oe[7:3]});
    check("R3", "pin_out[7:3]", {3'b0, pin_out[7:3]}, {3'b0, e_out[7:3]});
    check(spi_en ? "R6" : "R3", "pin_oe[2:0]", {5'b0, pin_oe[2:0]}, {5'b0, e_oe[2:0]});
    check(spi_en ? "R4" : "R10", "pin_out[1:0]", {6'b0, pin_out[1:0]}, {6'b0, e_out[1:0]});
    check(spi_en ? "R5" : "R10", "pin_out[2]", {7'b0, pin_out[2]}, {7'b0, e_out[2]});
    check("R7", "cpu_data_rd", cpu_data_rd, e_rd);
    check("R2", "cpu_dir_rd", cpu_dir_rd, m_dir);
    check("R9", "spi_sdi", {7'b0, spi_sdi}, {7'b0, e_sdi});
    check("R5", "spi_sck_in", {7'b0, spi_sck_in}, {7'b0, e_sck});
  endtask

  task automatic drive(logic [7:0] wd, logic dwe, logic rwe, logic [7:0] pins,
                       logic en, logic ms, logic sdo, logic sck);
    @(negedge clk);
    if (model_on) compare_all();
    cpu_wr_data = wd; cpu_data_we = dwe; cpu_dir_we = rwe; pin_in = pins;
    spi_en = en; spi_master = ms; spi_sdo = sdo; spi_sck_out = sck;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cpu_wr_data = 0; cpu_data_we = 0; cpu_dir_we = 0; pin_in = 0;
    spi_en = 0; spi_master = 0; spi_sdo = 0; spi_sck_out = 0;
    repeat (4) @(negedge clk);
    // R1: reset state while reset is held
    check("R1", "cpu_dir_rd", cpu_dir_rd, 8'h00);
    check("R1", "cpu_data_rd", cpu_data_rd, 8'h00);
    check("R1", "pin_oe", pin_oe, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_latch = 8'h00; m_dir = 8'h00; hist = '{8'h00, 8'h00};
    model_on = 1;

    phase = "R2";
    drive(8'hA5, 1, 0, 8'h00, 0, 0, 0, 0);
    drive(8'h0F, 0, 1, 8'h00, 0, 0, 0, 0);
    drive(8'hFF, 0, 1, 8'h3C, 0, 0, 0, 0);
    drive(8'h00, 0, 0, 8'h3C, 0, 0, 0, 0);

    phase = "R8";
    drive(8'h00, 0, 1, 8'h00, 0, 0, 0, 0);
    drive(8'h00, 0, 0, 8'h00, 0, 0, 0, 0);
    drive(8'h00, 0, 0, 8'h00, 0, 0, 0, 0);
    drive(8'h00, 0, 0, 8'hC3, 0, 0, 0, 0);
    @(negedge clk);
    compare_all();
    check("R8", "read after one edge", cpu_data_rd, 8'h00);
    @(negedge clk);
    compare_all();
    check("R8", "read after two edges", cpu_data_rd, 8'hC3);

    phase = "R6";
    drive(8'h07, 0, 1, 8'h05, 1, 0, 1, 1);
    drive(8'h5A, 1, 0, 8'h05, 1, 0, 0, 1);
    drive(8'h00, 0, 0, 8'h04, 1, 1, 1, 1);
    drive(8'h00, 0, 1, 8'h01, 1, 0, 1, 0);
    drive(8'h00, 0, 0, 8'h01, 1, 1, 0, 1);

    phase = "R10";
    drive(8'hFF, 0, 1, 8'h00, 1, 1, 1, 0);
    drive(8'h00, 0, 0, 8'h00, 0, 1, 1, 0);
    drive(8'h00, 0, 0, 8'h00, 0, 1, 1, 0);

    phase = "R3";
    for (int n = 0; n < 2000; n++) begin
      drive($urandom, ($urandom % 3) == 0, ($urandom % 4) == 0, $urandom,
            ($urandom % 2) == 0, $urandom, $urandom, $urandom);
    end
    drive(8'h00, 0, 0, 8'h00, 0, 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule